// File: doc/BRIEF.md
# Age-Ordered Store Forwarding Queue

This block keeps the stores that are in flight in a circular queue, in program order, and answers the lookups that loads make against them. The dispatch stage reserves an entry for each store. It receives a pointer that carries an extra wrap bit. When the store's operands are ready, the store deposits its address and data into its own entry. Retirement releases entries one per cycle from the oldest end. A flush discards everything that is still queued.

At decode, a load records the pointer of the most recent store dispatched before it, which is the allocation pointer minus one. When the load executes, it presents that pointer together with its address. The queue compares the address only against stores from the oldest queued entry up to and including the recorded one. If any of them match, it returns the data of the youngest match and raises a hit flag. Otherwise it passes the cache data input through. A recorded pointer that no longer lies inside the occupied region finds no older store and returns the cache data. This covers the case where that store has already retired, and the case where the queue was empty at decode.

Top module: `store_fwd_queue`

## Requirements
- R1: After a synchronous active-high reset the queue is empty, `sq_full` is 0, `alloc_ptr` is 0 and `ld_hit` is 0.
- R2: When `alloc_req` is high and the queue is not full, the entry at `alloc_ptr` (its low bits are the slot, its top bit is the wrap bit) becomes occupied on the next edge and `alloc_ptr` advances by one. `sq_full` is high exactly when DEPTH entries are occupied, and a request made while full changes nothing.
- R3: A write (`wr_en`, slot `wr_idx`) to an occupied entry stores `wr_addr` and `wr_data`, and lookups see them from the next cycle. A write to an unoccupied slot has no effect.
- R4: A lookup considers only occupied stores from the oldest one up to and including the slot of `ld_last_ptr`. Younger stores never supply data.
- R5: When several considered stores match `ld_addr`, the data comes from the one nearest to `ld_last_ptr` in program order.
- R6: A considered store whose address has not yet been written is treated as non-matching.
- R7: Lookups are combinational in the same cycle. On a miss `ld_hit` is 0 and `ld_data` equals `cache_data`.
- R8: `retire_req` frees the oldest entry on the next edge. A retire on an empty queue has no effect.
- R9: `flush` empties the queue on the next edge and takes priority over allocation, retirement and writes in that cycle.
- R10: If `ld_last_ptr` minus the head pointer, modulo twice DEPTH, is not below the occupancy count, the lookup misses.
- R11: Allocation, retirement and lookup ordering stay correct across many pointer wraparounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued stores |
| alloc_req | input | 1 | Reserve an entry for a dispatched store |
| alloc_ptr | output | IDX_W+1 | Pointer the next allocation receives |
| sq_full | output | 1 | All entries occupied |
| sq_empty | output | 1 | No entries occupied |
| retire_req | input | 1 | Free the oldest entry |
| wr_en | input | 1 | Store address/data write strobe |
| wr_idx | input | IDX_W | Slot being written |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_last_ptr | input | IDX_W+1 | Pointer of the youngest store older than the load |
| cache_data | input | DATA_W | Data from the cache path |
| ld_hit | output | 1 | An older store matched |
| ld_data | output | DATA_W | Forwarded store data or cache data |

## Verification
Pointer and occupancy outputs change one edge after an allocate, retire or flush. Address and data writes become visible to lookups one edge after the write. The lookup result is combinational, so it answers the inputs of the same cycle. The bench drives inputs just after a falling edge and compares every output against a behavioural queue model one nanosecond later, still in the same cycle. The model advances only after the following rising edge, so each compare sees exactly the state that the preceding edges produced.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    typedef enum logic [1:0] {
        PTR_HOLD     = 2'd0,
        PTR_PUSH     = 2'd1,
        PTR_POP      = 2'd2,
        PTR_PUSH_POP = 2'd3
    } ptr_op_e;

    function automatic ptr_op_e ptr_op(input logic push, input logic pop);
        ptr_op_e op;
        case ({pop, push})
            2'b01:   op = PTR_PUSH;
            2'b10:   op = PTR_POP;
            2'b11:   op = PTR_PUSH_POP;
            default: op = PTR_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/sfq_ptr_ctrl.sv
module sfq_ptr_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [IDX_W:0]   head_q,
    output logic [IDX_W:0]   tail_q,
    output logic [IDX_W:0]   count,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok
);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

    ptr_op_e op;

    assign count   = tail_q - head_q;
    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign push_ok = push_req & ~full & ~flush;
    assign pop_ok  = pop_req & ~empty & ~flush;
    assign op      = ptr_op(push_ok, pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            tail_q <= head_q;
        end else begin
            case (op)
                PTR_PUSH:     tail_q <= tail_q + ONE;
                PTR_POP:      head_q <= head_q + ONE;
                PTR_PUSH_POP: begin
                    tail_q <= tail_q + ONE;
                    head_q <= head_q + ONE;
                end
                default: ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tail_q - head_q) <= CAP); // R2

    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !flush) |=> $stable(tail_q)); // R2

    AST_EMPTY_HOLDS_HEAD: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req && !flush) |=> $stable(head_q)); // R8

    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R9

endmodule

// File: rtl/sfq_entry_array.sv
module sfq_entry_array #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          alloc_en,
    input  logic [IDX_W-1:0]              alloc_idx,
    input  logic                          free_en,
    input  logic [IDX_W-1:0]              free_idx,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0]              ent_valid,
    output logic [DEPTH-1:0]              ent_written,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_data
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        logic take_alloc;
        logic take_free;
        logic take_write;

        assign take_alloc = alloc_en && (alloc_idx == SLOT);
        assign take_free  = free_en && (free_idx == SLOT);
        assign take_write = wr_en && (wr_idx == SLOT) && ent_valid[g];

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent_valid[g]   <= 1'b0;
                ent_written[g] <= 1'b0;
            end else if (take_alloc) begin
                ent_valid[g]   <= 1'b1;
                ent_written[g] <= 1'b0;
            end else if (take_free) begin
                ent_valid[g]   <= 1'b0;
                ent_written[g] <= 1'b0;
            end else if (take_write) begin
                ent_written[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_addr[g] <= '0;
                ent_data[g] <= '0;
            end else if (take_write && !flush && !take_free) begin
                ent_addr[g] <= wr_addr;
                ent_data[g] <= wr_data;
            end
        end

        AST_WRITTEN_IS_OCCUPIED: assert property (@(posedge clk) disable iff (rst)
            ent_written[g] |-> ent_valid[g]); // R3

        AST_FREE_SLOT_IGNORES_WRITE: assert property (@(posedge clk) disable iff (rst)
            (!ent_valid[g] && !take_alloc) |=> !ent_written[g]); // R3
    end

endmodule

// File: rtl/sfq_age_search.sv
module sfq_age_search #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W:0]                head_q,
    input  logic [IDX_W:0]                count,
    input  logic [IDX_W:0]                last_ptr,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [DEPTH-1:0]              ent_valid,
    input  logic [DEPTH-1:0]              ent_written,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] span;
    logic             in_range;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] limit;
    logic [DEPTH-1:0] elig;
    logic [IDX_W-1:0] sel_idx;
    logic             any;

    assign span     = last_ptr - head_q;
    assign in_range = (span < count);
    assign head_idx = head_q[IDX_W-1:0];
    assign limit    = span[IDX_W-1:0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [IDX_W-1:0] age;
        assign age     = IDX_W'(g) - head_idx;
        assign elig[g] = in_range && ent_valid[g] && ent_written[g]
                         && (ent_addr[g] == ld_addr) && (age <= limit);
    end

    always_comb begin
        sel_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] slot;
            slot = head_idx + IDX_W'(k);
            if (elig[slot]) begin
                sel_idx = slot;
                any     = 1'b1;
            end
        end
    end

    assign hit      = any;
    assign hit_data = ent_data[sel_idx];

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              alloc_req,
    output logic [PTR_W-1:0]  alloc_ptr,
    output logic              sq_full,
    output logic              sq_empty,
    input  logic              retire_req,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PTR_W-1:0]  ld_last_ptr,
    input  logic [DATA_W-1:0] cache_data,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data
);

    logic [PTR_W-1:0]                 head_q;
    logic [PTR_W-1:0]                 tail_q;
    logic [PTR_W-1:0]                 count;
    logic                             push_ok;
    logic                             pop_ok;
    logic [DEPTH-1:0]                 ent_valid;
    logic [DEPTH-1:0]                 ent_written;
    logic [DEPTH-1:0][ADDR_W-1:0]     ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0]     ent_data;
    logic                             hit;
    logic [DATA_W-1:0]                hit_data;

    sfq_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push_req (alloc_req),
        .pop_req  (retire_req),
        .head_q   (head_q),
        .tail_q   (tail_q),
        .count    (count),
        .full     (sq_full),
        .empty    (sq_empty),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok)
    );

    sfq_entry_array #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ents (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .alloc_en    (push_ok),
        .alloc_idx   (tail_q[IDX_W-1:0]),
        .free_en     (pop_ok),
        .free_idx    (head_q[IDX_W-1:0]),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ent_valid   (ent_valid),
        .ent_written (ent_written),
        .ent_addr    (ent_addr),
        .ent_data    (ent_data)
    );

    sfq_age_search #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
        .head_q      (head_q),
        .count       (count),
        .last_ptr    (ld_last_ptr),
        .ld_addr     (ld_addr),
        .ent_valid   (ent_valid),
        .ent_written (ent_written),
        .ent_addr    (ent_addr),
        .ent_data    (ent_data),
        .hit         (hit),
        .hit_data    (hit_data)
    );

    assign alloc_ptr = tail_q;
    assign ld_hit    = hit;
    assign ld_data   = hit ? hit_data : cache_data;

    AST_HIT_NEEDS_STORE: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> !sq_empty); // R10

    AST_OCCUPANCY_MATCHES_VALID: assert property (@(posedge clk) disable iff (rst)
        $countones(ent_valid) == int'(count)); // R2

endmodule

// File: tb/store_fwd_queue_bench.sv
`timescale 1ns/1ps
module store_fwd_queue_bench;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;
    localparam int PTR_W  = 4;
    localparam int PMOD   = 2 * DEPTH;

    logic              clk = 1'b0;
    logic              rst;
    logic              flush;
    logic              alloc_req;
    logic [PTR_W-1:0]  alloc_ptr;
    logic              sq_full;
    logic              sq_empty;
    logic              retire_req;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] ld_addr;
    logic [PTR_W-1:0]  ld_last_ptr;
    logic [DATA_W-1:0] cache_data;
    logic              ld_hit;
    logic [DATA_W-1:0] ld_data;

    always #2.5 clk = ~clk;

    store_fwd_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store_fwd_queue (
        .clk, .rst, .flush, .alloc_req, .alloc_ptr, .sq_full, .sq_empty,
        .retire_req, .wr_en, .wr_idx, .wr_addr, .wr_data,
        .ld_addr, .ld_last_ptr, .cache_data, .ld_hit, .ld_data
    );

    int    total = 0;
    int    bad   = 0;
    string req   = "R1";
    bit    done  = 0;

    int          mh, mt;
    bit          mw   [DEPTH];
    logic [ADDR_W-1:0] ma [DEPTH];
    logic [DATA_W-1:0] md [DEPTH];

    function automatic int mcount();
        return (mt - mh + PMOD) % PMOD;
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int cnt, span, slot;
        bit exp_hit;
        logic [DATA_W-1:0] exp_data;
        cnt = mcount();
        span = (int'(ld_last_ptr) - mh + PMOD) % PMOD;
        exp_hit = 0;
        exp_data = cache_data;
        if (span < cnt) begin
            for (int k = 0; k <= span; k++) begin
                slot = (mh + k) % DEPTH;
                if (mw[slot] && ma[slot] == ld_addr) begin
                    exp_hit = 1;
                    exp_data = md[slot];
                end
            end
        end
        chk("alloc_ptr", 64'(alloc_ptr), 64'(mt));
        chk("sq_full", 64'(sq_full), 64'(cnt == DEPTH));
        chk("sq_empty", 64'(sq_empty), 64'(cnt == 0));
        chk("ld_hit", 64'(ld_hit), 64'(exp_hit));
        chk("ld_data", 64'(ld_data), 64'(exp_data));
    endtask

    task automatic model_edge();
        int cnt;
        cnt = mcount();
        if (rst) begin
            mh = 0; mt = 0;
            foreach (mw[i]) mw[i] = 0;
        end else if (flush) begin
            mt = mh;
            foreach (mw[i]) mw[i] = 0;
        end else begin
            if (wr_en && ((int'(wr_idx) - mh % DEPTH + DEPTH) % DEPTH) < cnt) begin
                mw[wr_idx] = 1; ma[wr_idx] = wr_addr; md[wr_idx] = wr_data;
            end
            if (retire_req && cnt > 0) begin
                mw[mh % DEPTH] = 0;
                mh = (mh + 1) % PMOD;
            end
            if (alloc_req && cnt < DEPTH) begin
                mw[mt % DEPTH] = 0;
                mt = (mt + 1) % PMOD;
            end
        end
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        alloc_req = 0; retire_req = 0; flush = 0; wr_en = 0; rst = 0;
    endtask

    task automatic wr(input int idx, input int a, input int d);
        wr_en = 1; wr_idx = IDX_W'(idx); wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    endtask

    task automatic look(input int a, input int last);
        ld_addr = ADDR_W'(a); ld_last_ptr = PTR_W'(last);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mh = 0; mt = 0;
        foreach (mw[i]) begin mw[i] = 0; ma[i] = '0; md[i] = '0; end
        rst = 1; flush = 0; alloc_req = 0; retire_req = 0; wr_en = 0;
        wr_idx = '0; wr_addr = '0; wr_data = '0;
        ld_addr = '0; ld_last_ptr = '1; cache_data = 32'hCAC0_0000;
        @(negedge clk);
        rst = 1; step(); rst = 1; step();

        // R1: reset state
        req = "R1";
        step();
        chk("R1 empty after reset", 64'(sq_empty), 64'd1);

        // R2: allocate three stores
        req = "R2";
        alloc_req = 1; step();
        alloc_req = 1; step();
        alloc_req = 1; step();
        chk("R2 alloc_ptr after three", 64'(alloc_ptr), 64'd3);

        // R3: write addresses A=0x10, B=0x20, A=0x10
        req = "R3";
        wr(0, 16'h10, 32'h1111); step();
        wr(1, 16'h20, 32'h2222); step();
        wr(2, 16'h10, 32'h3333); step();
        wr(6, 16'h10, 32'hBAD6); step();   // free slot, ignored

        // R5: youngest of two matches
        req = "R5";
        look(16'h10, 2); step();
        chk("R5 youngest match data", 64'(ld_data), 64'h3333);

        // R4: younger store excluded
        req = "R4";
        look(16'h10, 1); step();
        chk("R4 older-only data", 64'(ld_data), 64'h1111);
        look(16'h20, 0); step();
        chk("R4 younger B ignored", 64'(ld_hit), 64'd0);

        // R7: miss passes cache data
        req = "R7";
        cache_data = 32'hC0FFEE01;
        look(16'h99, 2); step();
        chk("R7 miss data", 64'(ld_data), 64'hC0FFEE01);

        // R6: unwritten older store does not match
        req = "R6";
        alloc_req = 1; step();
        look(16'h10, 3); step();
        chk("R6 skip unwritten", 64'(ld_data), 64'h3333);
        wr(3, 16'h10, 32'h4444); step();
        look(16'h10, 3); step();
        chk("R6 now written", 64'(ld_data), 64'h4444);

        // R2: fill to full, extra request ignored
        req = "R2";
        for (int i = 0; i < 4; i++) begin alloc_req = 1; step(); end
        chk("R2 full", 64'(sq_full), 64'd1);
        alloc_req = 1; step();
        chk("R2 full alloc ignored", 64'(alloc_ptr), 64'd8);
        // R3: the slot 6 write earlier left no data behind
        req = "R3";
        look(16'h10, 6); step();
        chk("R3 stale write absent", 64'(ld_data), 64'h4444);

        // R8: retire all plus one extra on empty
        req = "R8";
        for (int i = 0; i < 8; i++) begin retire_req = 1; step(); end
        chk("R8 empty after retire", 64'(sq_empty), 64'd1);
        retire_req = 1; step();
        chk("R8 retire on empty ignored", 64'(alloc_ptr), 64'd8);

        // R10: pointer outside occupied range
        req = "R10";
        alloc_req = 1; step();
        wr(0, 16'h10, 32'h5555); step();
        look(16'h10, 3); step();
        chk("R10 retired pointer misses", 64'(ld_hit), 64'd0);
        look(16'h10, 8); step();
        chk("R10 live pointer hits", 64'(ld_data), 64'h5555);

        // R9: flush beats alloc and retire
        req = "R9";
        alloc_req = 1; retire_req = 1; flush = 1; step();
        chk("R9 flushed empty", 64'(sq_empty), 64'd1);
        look(16'h10, 8); step();
        chk("R9 no hit after flush", 64'(ld_hit), 64'd0);

        // R11: random traffic with wraparound
        req = "R11";
        for (int n = 0; n < 4000; n++) begin
            int cnt;
            cnt = mcount();
            alloc_req  = ($urandom_range(0, 99) < 45);
            retire_req = ($urandom_range(0, 99) < 35);
            flush      = ($urandom_range(0, 99) < 2);
            if ($urandom_range(0, 99) < 60)
                wr($urandom_range(0, DEPTH - 1), $urandom_range(0, 3), $urandom);
            cache_data = $urandom;
            look($urandom_range(0, 3), (mh + $urandom_range(0, cnt) - 1 + PMOD) % PMOD);
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule